// File: doc/BRIEF.md
# Maskable Interrupt Controller With Output Modes

This block gathers up to fifteen single-cycle event pulses from a serial-bus terminal core and drives one interrupt line toward the host. The host reaches two registers through a simple strobe bus: a read/write enable register, and a read-only pending register. The top bit of the pending register is a summary flag that shows whether any enabled cause is pending. A host read of the pending register therefore shows every cause at once.

Two static inputs set the behaviour. `irq_mode_i` selects one of three line behaviours: a one-clock pulse, a level that only the clear strobe removes, or a level that a read of the pending register also removes. `rec_all_i` selects how causes are recorded. In filtered recording, a masked event leaves no trace. In record-all, every event is latched, but only enabled causes reach the line. A separate clear strobe empties the pending register in every mode.

The line is driven by a three-state machine. `ST_QUIET` means the line is low. `ST_PULSE` is a one-clock high. `ST_HOLD` is a sustained high. The transitions are:
- QUIET→PULSE: in pulse mode, the set of enabled pending causes gains a bit.
- QUIET→HOLD: in a level mode, any enabled cause becomes pending.
- PULSE→PULSE: another cause is gained.
- PULSE→QUIET: no cause is gained.
- PULSE→HOLD: the mode changes to a level mode while a cause is pending.
- HOLD→QUIET: nothing enabled is pending, or the mode is pulse with no gain.
- HOLD→PULSE: the mode is pulse and a cause is gained.

Top module: `irqc_top`

## Requirements
- R1: After reset the enable register is 0, the pending register is 0, `irq_o` is low and `rdata_o` is 0.
- R2: Address 0 is the enable register. Bits 14:0 can be written and read back, and bit 15 reads 0. A write to address 1 changes nothing. Addresses 2 and 3 read as 0.
- R3: With `rec_all_i`=0, pending bit k is set by `evt_i[k]` only when enable bit k, as held before that cycle, is 1.
- R4: With `rec_all_i`=1, pending bit k is set by `evt_i[k]` regardless of the enable bit. Only enabled pending bits affect `irq_o`.
- R5: A read of address 1 returns the pending bits in 14:0. Bit 15 is the OR of (pending AND enable), using the values held before the read.
- R6: With `irq_mode_i`=2'b00 (pulse), `irq_o` is high for one clock after each edge at which the set of enabled pending bits gains a bit, and low otherwise.
- R7: With `irq_mode_i`=2'b01 or 2'b11 (level, software clear), `irq_o` equals the OR of (pending AND enable), and a read leaves the pending bits unchanged.
- R8: With `irq_mode_i`=2'b10 (level, auto clear), a read of address 1 returns the pre-read value and clears the pending register. `irq_o` then drops unless a new enabled event arrived in the same cycle.
- R9: A pulse on `clr_i` clears every pending bit in every mode, so `irq_o` is low after it unless an enabled event arrived in the same cycle.
- R10: An event in the same cycle as a clearing read or a `clr_i` pulse stays latched after the clear.
- R11: `rdata_o` updates at the clock edge that samples `rd_en_i` and holds its value when no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 15 | Event pulses, one per cause |
| irq_mode_i | input | 2 | Line behaviour: 00 pulse, 01/11 level with software clear, 10 level with auto clear |
| rec_all_i | input | 1 | 1 = record events even when masked |
| clr_i | input | 1 | Clear strobe for all pending bits |
| addr_i | input | 2 | Register select |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| irq_o | output | 1 | Interrupt line |

## Verification
Some internal faults show up only on a later read. A wrongly latched or lost pending bit alters the next read of address 1 and its summary bit 15. A wrong state-machine state makes `irq_o` differ from the expected value at the very next edge. A read-clear that fires in the wrong mode, or that drops a same-cycle event, makes the following read disagree. The bench therefore mixes frequent reads with random events, so that such faults appear within a few cycles.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    typedef enum logic [1:0] {
        OM_PULSE    = 2'b00,
        OM_LVL_SW   = 2'b01,
        OM_LVL_AUTO = 2'b10,
        OM_LVL_ALT  = 2'b11
    } irq_mode_e;

    typedef enum logic [1:0] {
        ST_QUIET = 2'b00,
        ST_PULSE = 2'b01,
        ST_HOLD  = 2'b10
    } irq_state_e;

    localparam int REG_ENABLE  = 0;
    localparam int REG_PENDING = 1;
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int NUM_EVT = 15,
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               wr_en_i,
    input  logic               rd_en_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic [NUM_EVT-1:0] pend_q,
    output logic [NUM_EVT-1:0] mask_q,
    output logic [NUM_EVT-1:0] mask_nxt,
    output logic               pend_rd,
    output logic [DATA_W-1:0]  rdata_o
);
    localparam logic [ADDR_W-1:0] A_EN = ADDR_W'(REG_ENABLE);
    localparam logic [ADDR_W-1:0] A_PD = ADDR_W'(REG_PENDING);

    logic [DATA_W-1:0] rd_val;
    logic              summary;

    assign summary = |(pend_q & mask_q);
    assign pend_rd = rd_en_i && (addr_i == A_PD);

    always_comb begin
        mask_nxt = mask_q;
        if (wr_en_i && (addr_i == A_EN)) begin
            mask_nxt = wdata_i[NUM_EVT-1:0];
        end
    end

    always_comb begin
        rd_val = '0;
        if (addr_i == A_EN) begin
            rd_val[NUM_EVT-1:0] = mask_q;
        end else if (addr_i == A_PD) begin
            rd_val[NUM_EVT-1:0] = pend_q;
            rd_val[NUM_EVT]     = summary;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q  <= '0;
            rdata_o <= '0;
        end else begin
            mask_q <= mask_nxt;
            if (rd_en_i) begin
                rdata_o <= rd_val;
            end
        end
    end
endmodule

// File: rtl/irqc_pending.sv
module irqc_pending
    import irqc_pkg::*;
#(
    parameter int NUM_EVT = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic [NUM_EVT-1:0] mask_q,
    input  logic               rec_all_i,
    input  logic               clr_i,
    input  logic               pend_rd,
    input  logic [1:0]         irq_mode_i,
    output logic [NUM_EVT-1:0] pend_q,
    output logic [NUM_EVT-1:0] pend_nxt
);
    logic wipe;

    assign wipe = clr_i || (pend_rd && (irq_mode_e'(irq_mode_i) == OM_LVL_AUTO));

    for (genvar k = 0; k < NUM_EVT; k++) begin : g_bit
        logic take;
        assign take = evt_i[k] && (rec_all_i || mask_q[k]);
        always_comb begin
            if (take) begin
                pend_nxt[k] = 1'b1;
            end else if (wipe) begin
                pend_nxt[k] = 1'b0;
            end else begin
                pend_nxt[k] = pend_q[k];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_nxt;
        end
    end
endmodule

// File: rtl/irqc_line_fsm.sv
module irqc_line_fsm
    import irqc_pkg::*;
#(
    parameter int NUM_EVT = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         irq_mode_i,
    input  logic [NUM_EVT-1:0] live_old,
    input  logic [NUM_EVT-1:0] live_new,
    output logic               irq_o
);
    irq_state_e state_q, state_d;
    logic       pulse_mode, gain, any_live;

    assign pulse_mode = (irq_mode_e'(irq_mode_i) == OM_PULSE);
    assign gain       = |(live_new & ~live_old);
    assign any_live   = |live_new;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET: begin
                if (pulse_mode && gain)         state_d = ST_PULSE;
                else if (!pulse_mode && any_live) state_d = ST_HOLD;
                else                             state_d = ST_QUIET;
            end
            ST_PULSE: begin
                if (pulse_mode && gain)         state_d = ST_PULSE;
                else if (!pulse_mode && any_live) state_d = ST_HOLD;
                else                             state_d = ST_QUIET;
            end
            ST_HOLD: begin
                if (!pulse_mode && any_live)    state_d = ST_HOLD;
                else if (pulse_mode && gain)    state_d = ST_PULSE;
                else                             state_d = ST_QUIET;
            end
            default: state_d = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_PULSE, ST_HOLD: irq_o = 1'b1;
            default:           irq_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int NUM_EVT = 15,
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic [1:0]         irq_mode_i,
    input  logic               rec_all_i,
    input  logic               clr_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               wr_en_i,
    input  logic               rd_en_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  rdata_o,
    output logic               irq_o
);
    logic [NUM_EVT-1:0] mask_q, mask_nxt, pend_q, pend_nxt;
    logic               pend_rd;

    irqc_regs #(.NUM_EVT(NUM_EVT), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (addr_i),
        .wr_en_i  (wr_en_i),
        .rd_en_i  (rd_en_i),
        .wdata_i  (wdata_i),
        .pend_q   (pend_q),
        .mask_q   (mask_q),
        .mask_nxt (mask_nxt),
        .pend_rd  (pend_rd),
        .rdata_o  (rdata_o)
    );

    irqc_pending #(.NUM_EVT(NUM_EVT)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_i),
        .mask_q     (mask_q),
        .rec_all_i  (rec_all_i),
        .clr_i      (clr_i),
        .pend_rd    (pend_rd),
        .irq_mode_i (irq_mode_i),
        .pend_q     (pend_q),
        .pend_nxt   (pend_nxt)
    );

    irqc_line_fsm #(.NUM_EVT(NUM_EVT)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_mode_i (irq_mode_i),
        .live_old   (pend_q & mask_q),
        .live_new   (pend_nxt & mask_nxt),
        .irq_o      (irq_o)
    );
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
    parameter int NUM_EVT = 15,
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_EVT-1:0] evt_i,
    input logic [1:0]         irq_mode_i,
    input logic               rec_all_i,
    input logic               clr_i,
    input logic [ADDR_W-1:0]  addr_i,
    input logic               wr_en_i,
    input logic               rd_en_i,
    input logic [DATA_W-1:0]  rdata_o,
    input logic               irq_o,
    input logic [NUM_EVT-1:0] pend_q,
    input logic [NUM_EVT-1:0] mask_q
);
    // R7: level line follows enabled pending set
    p_level_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mode_i != 2'b00 && $stable(irq_mode_i)) |-> (irq_o == |(pend_q & mask_q)));

    // R6: no new input activity ends the pulse after one clock
    p_pulse_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mode_i == 2'b00 && irq_o && evt_i == '0 && !wr_en_i)
        |=> (!irq_o || irq_mode_i != 2'b00));

    // R3: filtered recording never sets a bit whose enable was clear
    p_filter_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rec_all_i |=> ((pend_q & ~$past(pend_q) & ~$past(mask_q)) == '0));

    // R9: clear strobe with no events empties the pending register
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && evt_i == '0) |=> (pend_q == '0));

    // R10: an accepted event is latched whatever else happens that cycle
    p_evt_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=>
        ((~pend_q & $past(evt_i) & ($past(rec_all_i) ? '1 : $past(mask_q))) == '0));

    // R5: summary bit of a pending read
    p_summary_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == ADDR_W'(1)) |=> (rdata_o[NUM_EVT] == |$past(pend_q & mask_q)));

    // R11: read data holds without a read
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rdata_o));
endmodule

bind irqc_top irqc_chk #(.NUM_EVT(NUM_EVT), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (evt_i),
    .irq_mode_i (irq_mode_i),
    .rec_all_i  (rec_all_i),
    .clr_i      (clr_i),
    .addr_i     (addr_i),
    .wr_en_i    (wr_en_i),
    .rd_en_i    (rd_en_i),
    .rdata_o    (rdata_o),
    .irq_o      (irq_o),
    .pend_q     (pend_q),
    .mask_q     (mask_q)
);

// File: tb/sim_irqc_top.sv
`timescale 1ns/1ps
module sim_irqc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] evt_i = '0;
    logic [1:0]  irq_mode_i = 2'b01;
    logic        rec_all_i = 1'b0;
    logic        clr_i = 1'b0;
    logic [1:0]  addr_i = '0;
    logic        wr_en_i = 1'b0;
    logic        rd_en_i = 1'b0;
    logic [15:0] wdata_i = '0;
    logic [15:0] rdata_o;
    logic        irq_o;

    int total = 0;
    int bad   = 0;

    logic [14:0] m_mask = '0;
    logic [14:0] m_pend = '0;
    logic [15:0] m_rdata = '0;

    always #2.5 clk = ~clk;

    irqc_top u0 (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .irq_mode_i(irq_mode_i),
        .rec_all_i(rec_all_i), .clr_i(clr_i), .addr_i(addr_i), .wr_en_i(wr_en_i),
        .rd_en_i(rd_en_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] read_val(input logic [1:0] a, input logic [14:0] mk,
                                             input logic [14:0] pd);
        if (a == 2'd0) return {1'b0, mk};
        if (a == 2'd1) return {|(pd & mk), pd};
        return 16'h0000;
    endfunction

    function automatic string line_tag(input logic [1:0] om);
        if (om == 2'b00) return "R6";
        if (om == 2'b10) return "R8";
        return "R7";
    endfunction

    // one clock of stimulus, model update and comparison
    task automatic step(input logic [14:0] ev, input logic clr, input logic [1:0] a,
                        input logic wr, input logic rd, input logic [15:0] wd, input string tag);
        logic [14:0] take, mask_n, pend_n, live_old, live_new;
        logic        wipe, exp_irq;
        string       t;
        evt_i = ev; clr_i = clr; addr_i = a; wr_en_i = wr; rd_en_i = rd; wdata_i = wd;
        wipe     = clr || (rd && a == 2'd1 && irq_mode_i == 2'b10);
        take     = ev & (rec_all_i ? 15'h7fff : m_mask);
        mask_n   = (wr && a == 2'd0) ? wd[14:0] : m_mask;
        pend_n   = (wipe ? 15'h0 : m_pend) | take;
        live_old = m_pend & m_mask;
        live_new = pend_n & mask_n;
        exp_irq  = (irq_mode_i == 2'b00) ? |(live_new & ~live_old) : |live_new;
        if (rd) m_rdata = read_val(a, m_mask, m_pend);
        @(posedge clk);
        @(negedge clk);
        m_mask = mask_n;
        m_pend = pend_n;
        t = (tag == "") ? line_tag(irq_mode_i) : tag;
        check(t, {15'h0, irq_o}, {15'h0, exp_irq});
        if (tag != "") t = tag;
        else if (!rd) t = "R11";
        else if (a == 2'd1) t = "R5";
        else t = "R2";
        check(t, rdata_o, m_rdata);
        evt_i = '0; clr_i = 0; wr_en_i = 0; rd_en_i = 0;
    endtask

    initial begin
        #(200000 * 5);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed;
        seed = 17;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R1 reset values seen before reset release
        check("R1", {15'h0, irq_o}, 16'h0);
        check("R1", rdata_o, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        step('0, 0, 2'd0, 0, 1, 0, "R1");
        step('0, 0, 2'd1, 0, 1, 0, "R1");
        // R2 enable register access and ignored writes
        step('0, 0, 2'd0, 1, 0, 16'hffff, "R2");
        step('0, 0, 2'd0, 0, 1, 0, "R2");
        step('0, 0, 2'd1, 1, 0, 16'h7fff, "R2");
        step('0, 0, 2'd1, 0, 1, 0, "R2");
        step('0, 0, 2'd2, 0, 1, 0, "R2");
        // R3 filtered recording
        step('0, 0, 2'd0, 1, 0, 16'h0001, "R3");
        step(15'h0006, 0, 2'd0, 0, 0, 0, "R3");
        step('0, 0, 2'd1, 0, 1, 0, "R3");
        // R4 record-all: masked bits latched, line stays low
        rec_all_i = 1'b1;
        step(15'h0006, 0, 2'd0, 0, 0, 0, "R4");
        step('0, 0, 2'd1, 0, 1, 0, "R4");
        step(15'h0001, 0, 2'd0, 0, 0, 0, "R4");
        // R9 clear strobe
        step('0, 1, 2'd0, 0, 0, 0, "R9");
        step('0, 0, 2'd1, 0, 1, 0, "R9");
        // R10 auto clear read with a same-cycle event
        irq_mode_i = 2'b10;
        step('0, 0, 2'd0, 1, 0, 16'h7fff, "R8");
        step(15'h0008, 0, 2'd0, 0, 0, 0, "R8");
        step(15'h0020, 0, 2'd1, 0, 1, 0, "R10");
        step('0, 0, 2'd1, 0, 1, 0, "R10");
        step('0, 0, 2'd1, 0, 1, 0, "R8");
        step(15'h0100, 1, 2'd0, 0, 0, 0, "R10");
        step('0, 0, 2'd1, 0, 1, 0, "R10");
        // R6 pulse
        irq_mode_i = 2'b00;
        step(15'h0002, 0, 2'd0, 0, 0, 0, "R6");
        step('0, 0, 2'd0, 0, 0, 0, "R6");
        step(15'h0002, 0, 2'd0, 0, 0, 0, "R6");
        // R7 software-clear level keeps bits across reads
        irq_mode_i = 2'b01;
        step('0, 0, 2'd1, 0, 1, 0, "R7");
        step('0, 0, 2'd1, 0, 1, 0, "R7");
        step('0, 1, 2'd0, 0, 0, 0, "R9");
        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [14:0] ev;
            logic [1:0]  a;
            if (i % 250 == 0) begin
                irq_mode_i = 2'($urandom);
                rec_all_i  = 1'($urandom);
            end
            ev = ($urandom % 4 == 0) ? 15'(1 << ($urandom % 15)) : 15'h0;
            if ($urandom % 16 == 0) ev = 15'($urandom);
            a = 2'($urandom % 4);
            step(ev, ($urandom % 40) == 0, a, ($urandom % 10) == 0,
                 ($urandom % 3) == 0, 16'($urandom), "");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule